// File: doc/BRIEF.md
# Folded 64-Point Inverse FFT Engine

This block computes a 64-point inverse transform over complex fixed-point samples by running one shared stage circuit three times. The stage circuit holds sixteen radix-4 butterflies, per-stage twiddle coefficients and a fixed stride shuffle. A small stage counter picks the twiddle set for each pass and picks the data source. The first pass reads the incoming frame, and the two later passes read a frame-wide feedback register.

A whole 64-sample frame moves in one transfer on each side, with valid/ready handshakes. The engine accepts a frame only while its counter is idle, so it takes a new frame at most once every three cycles. The result is held in a one-deep registered output slot. If that slot is still occupied when the last pass is ready, the engine waits at the last pass until the slot is drained.

Top module: `ifft_folded64`

## Requirements
- R1: A synchronous active-high `rst` leaves the engine idle: after reset `in_ready` is 1 and `out_valid` is 0.
- R2: `in_ready` is high only while the stage counter is idle. After a frame is taken (`in_valid` and `in_ready` high at a rising edge), `in_ready` stays low for the next two cycles, and `in_valid` asserted during those cycles has no effect on any result.
- R3: When the output slot is free, `out_valid` is first high after the third rising edge counted from the edge that took the frame.
- R4: Sample n sits at bits [32n+15:32n] (real part) and [32n+31:32n+16] (imaginary part) of a frame, both signed two's complement. Each pass splits the frame into groups b = 0..15 of samples 4b..4b+3. With twiddled inputs m0..m3, each group computes y0=m0+m2, y1=m0−m2, y2=m1+m3, y3=j·(m1−m3), and then z0=y0+y2, z1=y1+y3, z2=y0−y2, z3=y1−y3.
- R5: In pass s (0, 1, 2), input k of group b is multiplied by exp(+j2πe/64) with e = k·(b mod 4^s)·4^(2−s) mod 64. The coefficient parts are floor(16384·cos + 0.5) and floor(16384·sin + 0.5). Each product is rounded by adding 2^13 and then shifting arithmetically right by 14.
- R6: After the butterflies of every pass, output sample i takes butterfly result (i mod 4)·16 + (i div 4).
- R7: `out_data` equals the three passes applied in order to the taken frame. No division by 64 is applied, and every product and sum wraps to 16 bits.
- R8: At the last pass with `out_valid` high and `out_ready` low, the counter holds, `in_ready` stays low, and the pending result is not lost.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` do not change. A pop with no new result clears `out_valid`.
- R10: If the last pass completes in the same cycle that the consumer pops the slot, `out_valid` stays high and `out_data` takes the new result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input frame present |
| in_ready | output | 1 | Engine idle, frame can be taken |
| in_data | input | 2048 | Input frame, 64 complex samples |
| out_valid | output | 1 | Output slot holds a result |
| out_ready | input | 1 | Consumer pops the output slot |
| out_data | output | 2048 | Transformed frame, same layout |

## Verification
Two events can fall in the same cycle: completing the last pass into the output slot and the consumer popping that slot. They can also collide as stall versus progress, when a result waits while the next frame is already in flight. The bench provokes this by holding `out_ready` low, so the first result sits in the slot while a second frame runs up to its last pass and stalls there. It then raises `out_ready` for a single edge and judges that the slot is refilled with the second result in that same cycle, with `out_valid` never dropping. Random and directed frames are compared bit-exactly against a bench model of the pass recipe.

// File: rtl/ifft_pkg.sv
package ifft_pkg;

  localparam real PI_R = 3.14159265358979323846;

  function automatic int pow4(input int e);
    int r;
    r = 1;
    for (int i = 0; i < e; i++) r = r * 4;
    return r;
  endfunction

  // twiddle exponent for input k of butterfly b in pass s
  function automatic int twiddle_exp(input int s, input int b, input int k,
                                     input int n_pass, input int n);
    int m;
    m = (b % pow4(s)) * pow4(n_pass - 1 - s);
    return (k * m) % n;
  endfunction

  function automatic int tw_cos(input int e, input int n, input int frac);
    real a;
    a = 2.0 * PI_R * real'(e) / real'(n);
    return $rtoi($floor($cos(a) * real'(1 << frac) + 0.5));
  endfunction

  function automatic int tw_sin(input int e, input int n, input int frac);
    real a;
    a = 2.0 * PI_R * real'(e) / real'(n);
    return $rtoi($floor($sin(a) * real'(1 << frac) + 0.5));
  endfunction

  // stride shuffle: destination i reads source (i mod 4)*(n/4) + i div 4
  function automatic int shuffle_src(input int i, input int n);
    return (i % 4) * (n / 4) + (i / 4);
  endfunction

endpackage

// File: rtl/ifft_bfly4.sv
module ifft_bfly4 #(
  parameter int DW = 16,
  parameter int TW = 16,
  parameter int TF = 14
) (
  input  logic [8*DW-1:0] x_i,
  input  logic [4*TW-1:0] twr_i,
  input  logic [4*TW-1:0] twi_i,
  output logic [8*DW-1:0] z_o
);
  localparam int PW  = DW + TW + 2;
  localparam int RND = 1 << (TF - 1);

  logic signed [PW-1:0] xr_e [4];
  logic signed [PW-1:0] xi_e [4];
  logic signed [PW-1:0] tr_e [4];
  logic signed [PW-1:0] ti_e [4];
  logic signed [PW-1:0] pr   [4];
  logic signed [PW-1:0] pim  [4];
  logic signed [DW-1:0] mr   [4];
  logic signed [DW-1:0] mi   [4];
  logic signed [DW-1:0] yr   [4];
  logic signed [DW-1:0] yi   [4];
  logic signed [DW-1:0] dr, di;

  always_comb begin
    for (int k = 0; k < 4; k++) begin
      xr_e[k] = PW'($signed(x_i[2*DW*k +: DW]));
      xi_e[k] = PW'($signed(x_i[2*DW*k+DW +: DW]));
      tr_e[k] = PW'($signed(twr_i[TW*k +: TW]));
      ti_e[k] = PW'($signed(twi_i[TW*k +: TW]));
      pr[k]   = xr_e[k] * tr_e[k] - xi_e[k] * ti_e[k] + PW'(RND);
      pim[k]  = xr_e[k] * ti_e[k] + xi_e[k] * tr_e[k] + PW'(RND);
      mr[k]   = DW'(pr[k] >>> TF);
      mi[k]   = DW'(pim[k] >>> TF);
    end
    dr    = mr[1] - mr[3];
    di    = mi[1] - mi[3];
    yr[0] = mr[0] + mr[2];
    yi[0] = mi[0] + mi[2];
    yr[1] = mr[0] - mr[2];
    yi[1] = mi[0] - mi[2];
    yr[2] = mr[1] + mr[3];
    yi[2] = mi[1] + mi[3];
    yr[3] = -di;
    yi[3] = dr;
  end

  assign z_o[0*DW +: DW] = yr[0] + yr[2];
  assign z_o[1*DW +: DW] = yi[0] + yi[2];
  assign z_o[2*DW +: DW] = yr[1] + yr[3];
  assign z_o[3*DW +: DW] = yi[1] + yi[3];
  assign z_o[4*DW +: DW] = yr[0] - yr[2];
  assign z_o[5*DW +: DW] = yi[0] - yi[2];
  assign z_o[6*DW +: DW] = yr[1] - yr[3];
  assign z_o[7*DW +: DW] = yi[1] - yi[3];

endmodule

// File: rtl/ifft_stage.sv
module ifft_stage #(
  parameter int N      = 64,
  parameter int STAGES = 3,
  parameter int DW     = 16,
  parameter int TW     = 16,
  parameter int TF     = 14,
  parameter int SW     = 2
) (
  input  logic [SW-1:0]     stage_i,
  input  logic [N*2*DW-1:0] d_i,
  output logic [N*2*DW-1:0] d_o
);
  localparam int NB   = N / 4;
  localparam int SPW  = 2 * DW;
  localparam int NOPT = 1 << SW;

  logic [N*SPW-1:0] bf_out;

  for (genvar b = 0; b < NB; b++) begin : g_bf
    logic [4*TW-1:0] twr, twi;
    for (genvar k = 0; k < 4; k++) begin : g_in
      logic [TW-1:0] opt_r [NOPT];
      logic [TW-1:0] opt_i [NOPT];
      for (genvar s = 0; s < NOPT; s++) begin : g_s
        if (s < STAGES) begin : g_on
          localparam int E  = ifft_pkg::twiddle_exp(s, b, k, STAGES, N);
          localparam int CR = ifft_pkg::tw_cos(E, N, TF);
          localparam int CI = ifft_pkg::tw_sin(E, N, TF);
          assign opt_r[s] = TW'(CR);
          assign opt_i[s] = TW'(CI);
        end else begin : g_off
          assign opt_r[s] = '0;
          assign opt_i[s] = '0;
        end
      end
      assign twr[TW*k +: TW] = opt_r[stage_i];
      assign twi[TW*k +: TW] = opt_i[stage_i];
    end

    ifft_bfly4 #(.DW(DW), .TW(TW), .TF(TF)) u_bfly (
      .x_i  (d_i[4*SPW*b +: 4*SPW]),
      .twr_i(twr),
      .twi_i(twi),
      .z_o  (bf_out[4*SPW*b +: 4*SPW])
    );
  end

  for (genvar i = 0; i < N; i++) begin : g_shuf
    localparam int SRC = ifft_pkg::shuffle_src(i, N);
    assign d_o[SPW*i +: SPW] = bf_out[SPW*SRC +: SPW];
  end

endmodule

// File: rtl/ifft_folded64.sv
module ifft_folded64 #(
  parameter int N      = 64,
  parameter int STAGES = 3,
  parameter int DW     = 16,
  parameter int TW     = 16,
  parameter int TF     = 14
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [N*2*DW-1:0]   in_data,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [N*2*DW-1:0]   out_data
);
  localparam int SW   = (STAGES > 2) ? $clog2(STAGES) : 1;
  localparam int FW   = N * 2 * DW;
  localparam int LAST = STAGES - 1;

  logic [SW-1:0] stage_q;
  logic [FW-1:0] fb_q;
  logic [FW-1:0] src;
  logic [FW-1:0] res;
  logic          at_last, take, mid, emit;

  assign in_ready = (stage_q == '0);
  assign at_last  = (stage_q == SW'(LAST));
  assign take     = in_ready && in_valid;
  assign mid      = !in_ready && !at_last;
  assign emit     = at_last && (!out_valid || out_ready);
  assign src      = in_ready ? in_data : fb_q;

  ifft_stage #(
    .N(N), .STAGES(STAGES), .DW(DW), .TW(TW), .TF(TF), .SW(SW)
  ) u_stage (
    .stage_i(stage_q),
    .d_i    (src),
    .d_o    (res)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q   <= '0;
      out_valid <= 1'b0;
    end else begin
      if (take || mid) stage_q <= stage_q + SW'(1);
      else if (emit)   stage_q <= '0;
      if (emit)           out_valid <= 1'b1;
      else if (out_ready) out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (take || mid) fb_q     <= res;
    if (emit)        out_data <= res;
  end

endmodule

// File: rtl/ifft_folded64_chk.sv
module ifft_folded64_chk #(
  parameter int FW   = 2048,
  parameter int SW   = 2,
  parameter int LAST = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [FW-1:0] out_data,
  input logic [SW-1:0] stage_q
);

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (in_ready && !out_valid)); // R1

  AST_BUSY_AFTER_TAKE: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready); // R2

  AST_RISE_FROM_BUSY: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> !$past(in_ready)); // R3

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (stage_q == SW'(LAST) && out_valid && !out_ready) |=> (stage_q == SW'(LAST))); // R8

  AST_SLOT_STABLE: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R9

endmodule

bind ifft_folded64 ifft_folded64_chk #(.FW(FW), .SW(SW), .LAST(LAST)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_data (out_data),
  .stage_q  (stage_q)
);

// File: tb/ifft_folded64_tb.sv
`timescale 1ns/1ps
module ifft_folded64_tb;
  localparam int N      = 64;
  localparam int STAGES = 3;
  localparam int DW     = 16;
  localparam int TW     = 16;
  localparam int TF     = 14;
  localparam int FW     = N * 2 * DW;
  localparam real PI_T  = 3.14159265358979323846;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [FW-1:0] in_data = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [FW-1:0] out_data;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  int in_re [N];
  int in_im [N];
  logic [FW-1:0] exp_vec;

  always #2.5 clk = ~clk;

  ifft_folded64 #(.N(N), .STAGES(STAGES), .DW(DW), .TW(TW), .TF(TF)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );

  function automatic int wrap(input longint v);
    logic [DW-1:0] t;
    t = v[DW-1:0];
    return int'($signed(t));
  endfunction

  function automatic int p4(input int e);
    int r = 1;
    for (int i = 0; i < e; i++) r = r * 4;
    return r;
  endfunction

  function automatic int cw(input int e);
    return $rtoi($floor($cos(2.0 * PI_T * real'(e) / real'(N)) * 16384.0 + 0.5));
  endfunction

  function automatic int sw(input int e);
    return $rtoi($floor($sin(2.0 * PI_T * real'(e) / real'(N)) * 16384.0 + 0.5));
  endfunction

  function automatic logic [FW-1:0] pack_in();
    logic [FW-1:0] v;
    for (int n = 0; n < N; n++) begin
      v[2*DW*n +: DW]    = DW'(in_re[n]);
      v[2*DW*n+DW +: DW] = DW'(in_im[n]);
    end
    return v;
  endfunction

  // bench model of R4, R5, R6, R7
  function automatic logic [FW-1:0] model();
    int vr [N];
    int vi [N];
    int tr [N];
    int ti [N];
    logic [FW-1:0] v;
    for (int n = 0; n < N; n++) begin
      vr[n] = in_re[n];
      vi[n] = in_im[n];
    end
    for (int s = 0; s < STAGES; s++) begin
      for (int b = 0; b < N / 4; b++) begin
        int m;
        int mr [4];
        int mi [4];
        int yr [4];
        int yi [4];
        m = (b % p4(s)) * p4(STAGES - 1 - s);
        for (int k = 0; k < 4; k++) begin
          int e;
          longint a, c;
          e = (k * m) % N;
          a = longint'(vr[4*b+k]) * cw(e) - longint'(vi[4*b+k]) * sw(e) + 8192;
          c = longint'(vr[4*b+k]) * sw(e) + longint'(vi[4*b+k]) * cw(e) + 8192;
          mr[k] = wrap(a >>> TF);
          mi[k] = wrap(c >>> TF);
        end
        yr[0] = wrap(mr[0] + mr[2]);  yi[0] = wrap(mi[0] + mi[2]);
        yr[1] = wrap(mr[0] - mr[2]);  yi[1] = wrap(mi[0] - mi[2]);
        yr[2] = wrap(mr[1] + mr[3]);  yi[2] = wrap(mi[1] + mi[3]);
        yr[3] = wrap(-(mi[1] - mi[3])); yi[3] = wrap(mr[1] - mr[3]);
        tr[4*b]   = wrap(yr[0] + yr[2]); ti[4*b]   = wrap(yi[0] + yi[2]);
        tr[4*b+1] = wrap(yr[1] + yr[3]); ti[4*b+1] = wrap(yi[1] + yi[3]);
        tr[4*b+2] = wrap(yr[0] - yr[2]); ti[4*b+2] = wrap(yi[0] - yi[2]);
        tr[4*b+3] = wrap(yr[1] - yr[3]); ti[4*b+3] = wrap(yi[1] - yi[3]);
      end
      for (int i = 0; i < N; i++) begin
        vr[i] = tr[(i % 4) * (N / 4) + i / 4];
        vi[i] = ti[(i % 4) * (N / 4) + i / 4];
      end
    end
    for (int n = 0; n < N; n++) begin
      v[2*DW*n +: DW]    = DW'(vr[n]);
      v[2*DW*n+DW +: DW] = DW'(vi[n]);
    end
    return v;
  endfunction

  task automatic check_bit(input bit got, input bit want, input string req);
    n_checks++;
    if (got !== want) begin
      n_fails++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, got, want, $time);
    end
  endtask

  task automatic check_vec(input logic [FW-1:0] got, input logic [FW-1:0] want,
                           input string req);
    n_checks++;
    if (got !== want) begin
      n_fails++;
      for (int n = 0; n < N; n++) begin
        if (got[2*DW*n +: 2*DW] !== want[2*DW*n +: 2*DW]) begin
          $display("FAIL %s: sample %0d actual %h expected %h", req, n,
                   got[2*DW*n +: 2*DW], want[2*DW*n +: 2*DW]);
          break;
        end
      end
    end
  endtask

  task automatic clear_in();
    for (int n = 0; n < N; n++) begin
      in_re[n] = 0;
      in_im[n] = 0;
    end
  endtask

  task automatic fill_random(input int amp);
    for (int n = 0; n < N; n++) begin
      in_re[n] = int'($urandom_range(2 * amp)) - amp;
      in_im[n] = int'($urandom_range(2 * amp)) - amp;
    end
  endtask

  // one frame with a free output slot; junk in_valid while busy (R2)
  task automatic run_frame();
    logic [FW-1:0] want;
    want = model();
    check_bit(in_ready, 1'b1, "R2 idle before take");
    in_valid = 1'b1;
    in_data  = pack_in();
    @(posedge clk); #1;
    in_data  = {(FW/16){16'h7ff3}};
    for (int c = 0; c < STAGES - 1; c++) begin
      check_bit(in_ready, 1'b0, "R2 busy after take");
      check_bit(out_valid, 1'b0, "R3 no result yet");
      @(posedge clk); #1;
    end
    in_valid = 1'b0;
    check_bit(out_valid, 1'b1, "R3 result after third edge");
    check_vec(out_data, want, "R4/R5/R6/R7 frame result");
  endtask

  initial begin
    logic [FW-1:0] want_a, want_b;
    void'($urandom(32'd24681));
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    check_bit(in_ready, 1'b1, "R1 ready after reset");
    check_bit(out_valid, 1'b0, "R1 no output after reset");
    @(negedge clk);

    clear_in();
    run_frame();
    clear_in(); in_re[0] = 1000;
    run_frame();
    clear_in(); in_im[5] = -700;
    run_frame();
    clear_in();
    for (int n = 0; n < N; n++) in_re[n] = 100;
    run_frame();
    clear_in();
    for (int n = 0; n < N; n++) begin in_re[n] = 20000; in_im[n] = -32768; end
    run_frame();  // wraps at 16 bits, R7
    for (int f = 0; f < 6; f++) begin
      fill_random(512);
      run_frame();
    end
    fill_random(30000);
    run_frame();
    @(posedge clk); #1;
    check_bit(out_valid, 1'b0, "R9 pop with nothing new clears");

    // stall and same-cycle pop/refill: R8, R9, R10
    @(negedge clk);
    out_ready = 1'b0;
    fill_random(400);
    want_a = model();
    in_valid = 1'b1; in_data = pack_in();
    repeat (STAGES) begin @(posedge clk); #1; in_valid = 1'b0; end
    check_bit(out_valid, 1'b1, "R3 first result held");
    check_vec(out_data, want_a, "R7 first result");
    fill_random(400);
    want_b = model();
    in_valid = 1'b1; in_data = pack_in();
    @(posedge clk); #1;
    in_valid = 1'b0;
    for (int c = 0; c < 5; c++) begin
      @(posedge clk); #1;
      check_bit(in_ready, 1'b0, "R8 counter stalls at last pass");
      check_bit(out_valid, 1'b1, "R9 slot stays valid");
      check_vec(out_data, want_a, "R9 slot data stable");
    end
    out_ready = 1'b1;
    @(posedge clk); #1;
    check_bit(out_valid, 1'b1, "R10 valid kept on pop plus refill");
    check_vec(out_data, want_b, "R10 refilled with second result");
    check_bit(in_ready, 1'b1, "R8 counter released");
    @(posedge clk); #1;
    check_bit(out_valid, 1'b0, "R9 drained");

    @(negedge clk);
    fill_random(1000);
    run_frame();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule